// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when a small microcontroller core sleeps and how it comes back. Software writes a two-bit mode register: one bit requests a light sleep, in which only the CPU clock is stopped and timers, serial logic and interrupt logic keep running. The other bit requests a deep sleep, in which every clock enable drops. The write that sets a bit is the last instruction the core executes before it sleeps.

The block leaves a sleep state for one of three reasons. An enabled interrupt ends light sleep. A falling edge on any of the eight wake pins ends either sleep. A qualified reset ends either sleep. On every wake it raises a sticky wake flag and emits a one-cycle wake pulse. The pulse tells the core either to jump to the fixed wake vector or to resume at the next instruction. While the core sleeps, the block also supplies forced levels for the address-latch and program-fetch strobes, and a float request for the multiplexed low address/data port.

States: `ST_RUN`, `ST_IDLE`, `ST_PDOWN` and `ST_WAKE`. Transitions:
- run→idle: a mode write with only the light bit set.
- run→pdown: a mode write with the deep bit set.
- idle→wake: an interrupt request or a pin fall.
- pdown→wake: a pin fall.
- wake→run: always, after one cycle.
- any→run: on a qualified reset.

Top module: `pmc_lowpower_ctrl`

## Requirements
- R1: A mode write with `pcon_wdata`=2'b01 while running moves the block to light sleep on the next edge. `pcon_q` reads 2'b01 (bit 0 is light sleep), `cpu_clk_en` goes low and `periph_clk_en` stays high.
- R2: A mode write with bit 1 set while running moves the block to deep sleep. `pcon_q` bit 1 is set and both clock enables go low.
- R3: If both bits are written as 1 together, deep sleep wins, and `pcon_q` reads 2'b10.
- R4: In light sleep, `irq_req` high moves the block to the wake state on the next edge. Hardware clears the light bit, and the wake pulse reports resume (`wake_vec`=0). An interrupt request takes priority over a pin fall arriving in the same cycle.
- R5: A falling edge on any bit of `port_pins` wakes the block from light or deep sleep. The edge passes through a two-flop synchroniser first, so `wake_go` pulses three edges after the pin is first sampled low.
- R6: On a pin-fall wake, `wake_vec` is 1 and `vec_addr` equals 16'h0023 if `int_en` is high. If `int_en` is low, `wake_vec` is 0, which means resume at the next instruction.
- R7: Every wake sets `wake_flag`. `isr_ack` clears it. Without `isr_ack` the flag stays set.
- R8: `sys_reset` rises only after `rst_pin` has been high for 24 consecutive clock edges. A 23-edge pulse has no effect.
- R9: A qualified reset returns the block to run, clears `pcon_q` and clears `wake_flag`.
- R10: In light sleep, `pin_hold`=1 with `ale_lvl`=1 and `psen_lvl`=1. In deep sleep, `pin_hold`=1 with both levels 0. `p0_float` equals `ext_prog` in either sleep state and is 0 while running.
- R11: Three inputs are ignored: mode writes during sleep, `irq_req` during deep sleep, and pin falls while running. None of them changes `pcon_q` or produces a wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| arst_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin | input | 1 | Raw external reset request, active high |
| pcon_wr | input | 1 | Mode register write strobe |
| pcon_wdata | input | 2 | Mode write data: bit 0 light sleep, bit 1 deep sleep |
| irq_req | input | 1 | Any enabled interrupt pending |
| int_en | input | 1 | Global interrupt enable |
| port_pins | input | 8 | Wake pins, wake on falling edge |
| isr_ack | input | 1 | Core has entered the wake service routine |
| ext_prog | input | 1 | Core fetches from external program memory |
| sys_reset | output | 1 | Qualified reset to the rest of the chip |
| pcon_q | output | 2 | Mode register contents |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral and interrupt clock enable |
| wake_go | output | 1 | One-cycle wake pulse |
| wake_vec | output | 1 | With wake_go: 1 jump to vector, 0 resume |
| vec_addr | output | 16 | Wake vector address while a vector wake is pulsing |
| wake_flag | output | 1 | Sticky wake indication |
| pin_hold | output | 1 | Bus strobes are forced to sleep levels |
| ale_lvl | output | 1 | Forced address-latch strobe level |
| psen_lvl | output | 1 | Forced program-fetch strobe level |
| p0_float | output | 1 | Float request for the low address/data port |

## Verification
The assertions assume several things about the inputs. `rst_pin` is synchronous to `clk`. The core raises `isr_ack` only after a wake. The wake pins rest high between falls, so each fall appears as one clean edge after synchronisation. The stimulus drives every input on the falling clock edge. It holds each wake pin low for at least three edges and then returns it high. It pulses `irq_req` only while a sleep state is being tested or ignored. Random sleep modes, interrupt-enable values, program-memory sources and wake pins are drawn from a fixed seed.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_PDOWN = 2'd2,
        ST_WAKE  = 2'd3
    } pmc_state_e;

    typedef struct packed {
        logic pd;
        logic idle;
    } pmc_mode_t;
endpackage

// File: rtl/pmc_port_fall.sv
module pmc_port_fall #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic [N_PINS-1:0] pins,
    output logic              fall_any
);
    logic [N_PINS-1:0] fall_bit;

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic s1, s2, s3;
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                s1 <= 1'b1;
                s2 <= 1'b1;
                s3 <= 1'b1;
            end else begin
                s1 <= pins[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign fall_bit[i] = s3 & ~s2;
    end

    assign fall_any = |fall_bit;
endmodule

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
    parameter int HOLD = 24
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_pin,
    output logic sys_reset
);
    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            cnt <= '0;
        else if (!rst_pin)
            cnt <= '0;
        else if (cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assign sys_reset = (cnt == CNT_MAX);

    // R8: a qualified reset is only seen while the pin was held on the previous edge
    p_reset_needs_pin_r8: assert property (@(posedge clk) disable iff (!arst_n)
        sys_reset |-> $past(rst_pin));
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       sys_reset,
    input  logic       pcon_wr,
    input  logic [1:0] pcon_wdata,
    input  logic       irq_req,
    input  logic       int_en,
    input  logic       port_fall,
    input  logic       isr_ack,
    input  logic       ext_prog,
    output pmc_mode_t  mode_q,
    output logic       wake_flag,
    output logic       wake_go,
    output logic       wake_vec,
    output logic       cpu_clk_en,
    output logic       periph_clk_en,
    output logic       pin_hold,
    output logic       ale_lvl,
    output logic       psen_lvl,
    output logic       p0_float
);
    pmc_state_e state, state_n;
    pmc_mode_t  mode_n;
    logic       vec_q, vec_n;
    logic       wake_enter;

    // next-state logic
    always_comb begin
        state_n = state;
        mode_n  = mode_q;
        vec_n   = vec_q;
        unique case (state)
            ST_RUN: begin
                if (pcon_wr && pcon_wdata[1]) begin
                    state_n = ST_PDOWN;
                    mode_n  = '{pd: 1'b1, idle: 1'b0};
                end else if (pcon_wr && pcon_wdata[0]) begin
                    state_n = ST_IDLE;
                    mode_n  = '{pd: 1'b0, idle: 1'b1};
                end
            end
            ST_IDLE: begin
                if (irq_req) begin
                    state_n = ST_WAKE;
                    mode_n  = '0;
                    vec_n   = 1'b0;
                end else if (port_fall) begin
                    state_n = ST_WAKE;
                    mode_n  = '0;
                    vec_n   = int_en;
                end
            end
            ST_PDOWN: begin
                if (port_fall) begin
                    state_n = ST_WAKE;
                    mode_n  = '0;
                    vec_n   = int_en;
                end
            end
            ST_WAKE: begin
                state_n = ST_RUN;
            end
            default: state_n = ST_RUN;
        endcase
    end

    assign wake_enter = (state_n == ST_WAKE) && (state != ST_WAKE);

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state     <= ST_RUN;
            mode_q    <= '0;
            vec_q     <= 1'b0;
            wake_flag <= 1'b0;
        end else if (sys_reset) begin
            state     <= ST_RUN;
            mode_q    <= '0;
            vec_q     <= 1'b0;
            wake_flag <= 1'b0;
        end else begin
            state  <= state_n;
            mode_q <= mode_n;
            vec_q  <= vec_n;
            if (wake_enter)
                wake_flag <= 1'b1;
            else if (isr_ack)
                wake_flag <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        cpu_clk_en    = 1'b1;
        periph_clk_en = 1'b1;
        pin_hold      = 1'b0;
        ale_lvl       = 1'b1;
        psen_lvl      = 1'b1;
        p0_float      = 1'b0;
        wake_go       = 1'b0;
        wake_vec      = 1'b0;
        unique case (state)
            ST_RUN: ;
            ST_IDLE: begin
                cpu_clk_en = 1'b0;
                pin_hold   = 1'b1;
                p0_float   = ext_prog;
            end
            ST_PDOWN: begin
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
                pin_hold      = 1'b1;
                ale_lvl       = 1'b0;
                psen_lvl      = 1'b0;
                p0_float      = ext_prog;
            end
            ST_WAKE: begin
                wake_go  = 1'b1;
                wake_vec = vec_q;
            end
            default: ;
        endcase
    end

    p_idle_entry_r1: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_RUN && pcon_wr && pcon_wdata == 2'b01 && !sys_reset)
        |=> (!cpu_clk_en && periph_clk_en && mode_q.idle));

    p_pd_freeze_r2: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(mode_q.pd) |-> (!cpu_clk_en && !periph_clk_en));

    p_pd_wins_r3: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_RUN && pcon_wr && pcon_wdata[1] && !sys_reset)
        |=> (mode_q.pd && !mode_q.idle));

    p_irq_wakes_idle_r4: assert property (@(posedge clk) disable iff (!arst_n)
        (mode_q.idle && irq_req && !sys_reset) |=> (wake_go && !wake_vec && !mode_q.idle));

    p_flag_on_wake_r7: assert property (@(posedge clk) disable iff (!arst_n)
        wake_go |-> wake_flag);

    p_strobes_r10: assert property (@(posedge clk) disable iff (!arst_n)
        pin_hold |-> (ale_lvl == psen_lvl) && (ale_lvl == mode_q.idle));

    p_pd_ignores_irq_r11: assert property (@(posedge clk) disable iff (!arst_n)
        (mode_q.pd && !port_fall && !sys_reset) |=> mode_q.pd);

    p_one_mode_r3: assert property (@(posedge clk) disable iff (!arst_n)
        !(mode_q.pd && mode_q.idle));
endmodule

// File: rtl/pmc_lowpower_ctrl.sv
module pmc_lowpower_ctrl
    import pmc_pkg::*;
#(
    parameter int               N_PINS   = 8,
    parameter int               RST_HOLD = 24,
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WAKE_VEC = 16'h0023
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              rst_pin,
    input  logic              pcon_wr,
    input  logic [1:0]        pcon_wdata,
    input  logic              irq_req,
    input  logic              int_en,
    input  logic [N_PINS-1:0] port_pins,
    input  logic              isr_ack,
    input  logic              ext_prog,
    output logic              sys_reset,
    output logic [1:0]        pcon_q,
    output logic              cpu_clk_en,
    output logic              periph_clk_en,
    output logic              wake_go,
    output logic              wake_vec,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              wake_flag,
    output logic              pin_hold,
    output logic              ale_lvl,
    output logic              psen_lvl,
    output logic              p0_float
);
    logic      port_fall;
    pmc_mode_t mode_q;

    pmc_rst_qual #(.HOLD(RST_HOLD)) u_rst (
        .clk       (clk),
        .arst_n    (arst_n),
        .rst_pin   (rst_pin),
        .sys_reset (sys_reset)
    );

    pmc_port_fall #(.N_PINS(N_PINS)) u_fall (
        .clk      (clk),
        .arst_n   (arst_n),
        .pins     (port_pins),
        .fall_any (port_fall)
    );

    pmc_fsm u_fsm (
        .clk           (clk),
        .arst_n        (arst_n),
        .sys_reset     (sys_reset),
        .pcon_wr       (pcon_wr),
        .pcon_wdata    (pcon_wdata),
        .irq_req       (irq_req),
        .int_en        (int_en),
        .port_fall     (port_fall),
        .isr_ack       (isr_ack),
        .ext_prog      (ext_prog),
        .mode_q        (mode_q),
        .wake_flag     (wake_flag),
        .wake_go       (wake_go),
        .wake_vec      (wake_vec),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .pin_hold      (pin_hold),
        .ale_lvl       (ale_lvl),
        .psen_lvl      (psen_lvl),
        .p0_float      (p0_float)
    );

    assign pcon_q   = mode_q;
    assign vec_addr = (wake_go && wake_vec) ? WAKE_VEC : '0;

    p_reset_clears_r9: assert property (@(posedge clk) disable iff (!arst_n)
        sys_reset |=> (pcon_q == 2'b00 && !wake_flag && cpu_clk_en));

    p_pin_wake_r5: assert property (@(posedge clk) disable iff (!arst_n)
        (port_fall && pcon_q != 2'b00 && !irq_req && !sys_reset) |=> wake_go);
endmodule

// File: tb/sim_pmc_lowpower_ctrl.sv
module sim_pmc_lowpower_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic rst_pin = 1'b0, pcon_wr = 1'b0, irq_req = 1'b0, int_en = 1'b0;
    logic isr_ack = 1'b0, ext_prog = 1'b0;
    logic [1:0] pcon_wdata = 2'b00;
    logic [7:0] port_pins = 8'hFF;
    logic sys_reset, cpu_clk_en, periph_clk_en, wake_go, wake_vec, wake_flag;
    logic pin_hold, ale_lvl, psen_lvl, p0_float;
    logic [1:0] pcon_q;
    logic [15:0] vec_addr;

    int errors = 0, checks = 0;
    int nvec = 0, nres = 0;
    logic [15:0] last_addr = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmc_lowpower_ctrl u0 (
        .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .pcon_wr(pcon_wr),
        .pcon_wdata(pcon_wdata), .irq_req(irq_req), .int_en(int_en),
        .port_pins(port_pins), .isr_ack(isr_ack), .ext_prog(ext_prog),
        .sys_reset(sys_reset), .pcon_q(pcon_q), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .wake_go(wake_go), .wake_vec(wake_vec),
        .vec_addr(vec_addr), .wake_flag(wake_flag), .pin_hold(pin_hold),
        .ale_lvl(ale_lvl), .psen_lvl(psen_lvl), .p0_float(p0_float)
    );

    always @(negedge clk) begin
        if (arst_n && wake_go) begin
            if (wake_vec) begin
                nvec++;
                last_addr = vec_addr;
            end else begin
                nres++;
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_mode(logic [1:0] w);
        return w[1] ? 2'b10 : (w[0] ? 2'b01 : 2'b00);
    endfunction

    function automatic logic [3:0] exp_pins(logic [1:0] m, logic ext);
        // {pin_hold, ale, psen, p0_float}
        if (m == 2'b01) return {3'b111, ext};
        if (m == 2'b10) return {3'b100, ext};
        return 4'b0110;
    endfunction

    task automatic enter(logic [1:0] w);
        pcon_wr = 1'b1; pcon_wdata = w;
        tick(1);
        pcon_wr = 1'b0; pcon_wdata = 2'b00;
    endtask

    task automatic pin_fall(int b);
        port_pins[b] = 1'b0;
        tick(3);
        port_pins[b] = 1'b1;
        tick(4);
    endtask

    task automatic irq_wake();
        irq_req = 1'b1;
        tick(1);
        irq_req = 1'b0;
        tick(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v0, r0;
        void'($urandom(32'h5EED_1234));
        tick(2);
        arst_n = 1'b1;
        tick(2);
        // reset state
        chk("R9 reset pcon", pcon_q, 2'b00);
        chk("R9 reset clocks", {cpu_clk_en, periph_clk_en}, 2'b11);
        chk("R7 reset flag", wake_flag, 1'b0);
        chk("R8 reset idle", sys_reset, 1'b0);

        // R1 light sleep
        ext_prog = 1'b1;
        enter(2'b01);
        chk("R1 pcon", pcon_q, 2'b01);
        chk("R1 clocks", {cpu_clk_en, periph_clk_en}, 2'b01);
        chk("R10 idle pins", {pin_hold, ale_lvl, psen_lvl, p0_float}, exp_pins(2'b01, 1'b1));
        // R11 mode write in sleep ignored
        enter(2'b10);
        chk("R11 write in sleep", pcon_q, 2'b01);

        // R4 interrupt wake
        r0 = nres; v0 = nvec;
        int_en = 1'b1;
        irq_wake();
        chk("R4 pcon cleared", pcon_q, 2'b00);
        chk("R4 resume pulse", nres - r0, 1);
        chk("R4 no vector", nvec - v0, 0);
        chk("R7 flag set", wake_flag, 1'b1);
        isr_ack = 1'b1; tick(1); isr_ack = 1'b0;
        chk("R7 flag cleared", wake_flag, 1'b0);

        // R2 R3 deep sleep with both bits
        enter(2'b11);
        chk("R3 pd precedence", pcon_q, 2'b10);
        chk("R2 clocks off", {cpu_clk_en, periph_clk_en}, 2'b00);
        chk("R10 pd pins", {pin_hold, ale_lvl, psen_lvl, p0_float}, exp_pins(2'b10, 1'b1));
        r0 = nres; v0 = nvec;
        irq_req = 1'b1; tick(3); irq_req = 1'b0; tick(2);
        chk("R11 irq in pd", pcon_q, 2'b10);
        chk("R11 irq in pd pulses", (nres - r0) + (nvec - v0), 0);

        // R5 R6 pin wake with vector
        pin_fall(5);
        chk("R5 pd wake", pcon_q, 2'b00);
        chk("R6 vector pulse", nvec - v0, 1);
        chk("R6 vector addr", last_addr, 16'h0023);
        isr_ack = 1'b1; tick(1); isr_ack = 1'b0;

        // R11 pin fall while running
        r0 = nres; v0 = nvec;
        pin_fall(0);
        chk("R11 fall in run", (nres - r0) + (nvec - v0), 0);
        chk("R11 fall in run flag", wake_flag, 1'b0);

        // R6 R7 resume without interrupts, flag sticky
        int_en = 1'b0; ext_prog = 1'b0;
        enter(2'b01);
        chk("R10 no float", p0_float, 1'b0);
        pin_fall(7);
        chk("R6 resume pulse", nres - r0, 1);
        tick(5);
        chk("R7 flag sticky", wake_flag, 1'b1);

        // R8 short pulse
        rst_pin = 1'b1; tick(23);
        chk("R8 23 edges", sys_reset, 1'b0);
        rst_pin = 1'b0; tick(2);
        chk("R8 short no effect", wake_flag, 1'b1);

        // R8 R9 qualified reset from light sleep
        enter(2'b01);
        rst_pin = 1'b1; tick(23);
        chk("R8 before hold", sys_reset, 1'b0);
        tick(1);
        chk("R8 after hold", sys_reset, 1'b1);
        tick(1);
        chk("R9 pcon cleared", pcon_q, 2'b00);
        chk("R9 flag cleared", wake_flag, 1'b0);
        chk("R9 clocks on", {cpu_clk_en, periph_clk_en}, 2'b11);
        rst_pin = 1'b0; tick(2);
        chk("R8 release", sys_reset, 1'b0);

        // random mix
        for (int it = 0; it < 24; it++) begin
            logic [1:0] w;
            logic use_irq, ien, ext;
            int b;
            w = 2'($urandom_range(1, 3));
            ien = 1'($urandom);
            ext = 1'($urandom);
            b = $urandom_range(0, 7);
            use_irq = (exp_mode(w) == 2'b01) && 1'($urandom);
            int_en = ien; ext_prog = ext;
            enter(w);
            chk("R1/R2 rand mode", pcon_q, exp_mode(w));
            chk("R10 rand pins", {pin_hold, ale_lvl, psen_lvl, p0_float}, exp_pins(exp_mode(w), ext));
            chk("R2 rand periph", periph_clk_en, exp_mode(w) != 2'b10);
            r0 = nres; v0 = nvec;
            if (use_irq) irq_wake(); else pin_fall(b);
            chk("R5 rand woke", pcon_q, 2'b00);
            chk("R6 rand vector", nvec - v0, (!use_irq && ien) ? 1 : 0);
            chk("R6 rand resume", nres - r0, (!use_irq && ien) ? 0 : 1);
            chk("R7 rand flag", wake_flag, 1'b1);
            if (1'($urandom)) begin
                isr_ack = 1'b1; tick(1); isr_ack = 1'b0;
                chk("R7 rand ack", wake_flag, 1'b0);
            end
            tick(1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule